// File: doc/BRIEF.md
# Packet Receive Memory Address Generator

This block sits behind a serial link receiver and turns its character stream into word writes into a memory segment. Each character is either a data byte or a packet terminator (normal or error). Bytes are packed little-endian into 16-bit or 32-bit words. Narrow and partial words can be sign-extended or zero-filled to the 32-bit bus. Each finished word is written at the segment start address plus a running word index.

A host arms the generator with a segment start, a segment length in words and a format. In single-packet mode the generator stops at the first terminator and reports how the packet ended and how many words it wrote. It then accepts nothing until the host arms it again. In multi-packet mode packets are stored back to back without any per-packet event. The generator reports completion only when the last word of the segment has been written, so the host must find packet boundaries itself. While idle or finished the block holds its input ready low, so no byte is dropped and no write lands outside the segment.

Top module: `rxseg_addrgen`

## Requirements
- R1: After reset the block is idle. `in_ready`, `done`, `done_irq`, `mem_we`, `st_eep`, `st_ovf` are 0 and `st_words` is 0.
- R2: An `arm` pulse while idle or finished does four things. It captures `cfg_base`, `cfg_len`, `cfg_wide`, `cfg_sext` and `cfg_multi`, clears `st_words`, `st_eep` and `st_ovf`, and raises `in_ready` from the next cycle. An `arm` pulse while running is ignored: the captured settings and the write position are unchanged.
- R3: `in_kind` is coded as 2'b00 for a data byte, 2'b01 for a normal terminator, and 2'b10 or 2'b11 for an error terminator. Data bytes fill a word little-endian: the first byte goes to bits 7:0, the next to 15:8, and so on. A word is written once it holds 2 bytes (`cfg_wide`=0) or 4 bytes (`cfg_wide`=1). The write goes to address `base + st_words` (modulo 2^ADDR_W), with `mem_we` high for one cycle.
- R4: In 16-bit mode, bits 31:16 of a written word are 0, or copies of bit 15 when `cfg_sext`=1.
- R5: A terminator that arrives while a word is partly filled flushes that word. Its unused upper bytes are 0, or copies of the top bit of the last received byte when `cfg_sext`=1. A terminator on an empty word writes nothing.
- R6: In single-packet mode a terminator stops the generator. `done` goes to 1 and `done_irq` pulses for exactly one cycle. `st_eep` is 1 if the terminator was an error terminator.
- R7: While finished, `in_ready` is 0, no input is accepted, no write occurs and `done` stays 1 until the next `arm`.
- R8: In single-packet mode, if the segment's last word is written before a terminator arrives, the generator stops. It sets `st_ovf`=1, `done`=1 and pulses `done_irq`.
- R9: In multi-packet mode a terminator only flushes a partial word; the generator keeps running. Packets are stored at consecutive addresses. The generator stops with one `done_irq` pulse when the word that fills the segment is written, and `st_ovf` and `st_eep` stay 0.
- R10: `st_words` equals the number of words written since the last accepted `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Segment start word address, captured at arm |
| cfg_len | input | LEN_W | Segment length in words (at least 1), captured at arm |
| cfg_wide | input | 1 | 1: 32-bit words, 0: 16-bit words |
| cfg_sext | input | 1 | 1: sign-fill narrow and partial words |
| cfg_multi | input | 1 | 1: multi-packet mode, 0: single-packet mode |
| arm | input | 1 | Start pulse |
| in_valid | input | 1 | Input character valid |
| in_byte | input | 8 | Data byte |
| in_kind | input | 2 | Character kind: 00 data, 01 end, 1x error end |
| in_ready | output | 1 | Input accepted this cycle when high with in_valid |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write word address |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | Generator finished |
| done_irq | output | 1 | One-cycle completion pulse |
| st_eep | output | 1 | Single-packet stop was caused by an error terminator |
| st_ovf | output | 1 | Single-packet segment filled before a terminator |
| st_words | output | LEN_W | Words written since arm |

## Verification
The hardest situation to reach is the end of a multi-packet segment. There, a packet terminator must leave the generator running while a later data byte completes the final word. The stimulus arms a three-word segment and sends a packet that ends on a partial word, so a flush occurs. It then sends a packet that ends exactly on a word boundary, so no flush occurs, and checks that the generator is still running. A third packet then fills the last word. The single-packet overflow is reached by giving a two-word segment a nine-byte packet; the ninth byte must meet a low `in_ready`.

// File: rtl/rxseg_pkg.sv
package rxseg_pkg;

    // Bus is always 32 bits wide; a word is 2 or 4 byte lanes of it.
    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gen_state_e;

    // Character kind codes on in_kind
    localparam logic [1:0] KIND_DATA = 2'b00;
    localparam logic [1:0] KIND_END  = 2'b01;

endpackage

// File: rtl/rxseg_word_fill.sv
module rxseg_word_fill #(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES*8-1:0] acc,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic               sext,
    output logic [LANES*8-1:0] word
);

    logic top_bit;

    // Top bit of the highest valid byte
    always_comb begin
        top_bit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (nbytes == CNT_W'(i + 1)) begin
                top_bit = acc[8*i+7];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word[8*g +: 8] = (CNT_W'(g) < nbytes) ? acc[8*g +: 8]
                                                      : {8{sext & top_bit}};
    end

endmodule

// File: rtl/rxseg_seg_addr.sv
module rxseg_seg_addr #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  count_inc,
    output logic              last
);

    assign addr      = base + ADDR_W'(count);
    assign count_inc = count + 1'b1;
    assign last      = (count_inc == len);

endmodule

// File: rtl/rxseg_addrgen.sv
module rxseg_addrgen
    import rxseg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_wide,
    input  logic              cfg_sext,
    input  logic              cfg_multi,
    input  logic              arm,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [1:0]        in_kind,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic              done,
    output logic              done_irq,
    output logic              st_eep,
    output logic              st_ovf,
    output logic [LEN_W-1:0]  st_words
);

    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef struct packed {
        gen_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic              wide;
        logic              sext;
        logic              multi;
        logic [LEN_W-1:0]  words;
        logic [LANE_W-1:0] lane;
        logic [BUS_W-1:0]  acc;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
        logic              irq;
        logic              eep;
        logic              ovf;
    } regs_t;

    regs_t r_d, r_q;

    logic [BUS_W-1:0]  acc_ins;
    logic [BUS_W-1:0]  full_word;
    logic [BUS_W-1:0]  flush_word;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  words_inc;
    logic              seg_last;
    logic [LANE_W-1:0] last_lane;
    logic [CNT_W-1:0]  full_cnt;
    logic [CNT_W-1:0]  part_cnt;
    logic              is_data;
    logic              take;

    // Settings captured at arm, exposed for the checker
    logic wide_q, sext_q, multi_q;
    assign wide_q  = r_q.wide;
    assign sext_q  = r_q.sext;
    assign multi_q = r_q.multi;

    // Drop the incoming byte into its lane
    always_comb begin
        acc_ins = r_q.acc;
        acc_ins[8*r_q.lane +: 8] = in_byte;
    end

    assign last_lane = r_q.wide ? LANE_W'(LANES - 1) : LANE_W'(1);
    assign full_cnt  = CNT_W'(r_q.lane) + 1'b1;
    assign part_cnt  = CNT_W'(r_q.lane);

    rxseg_word_fill #(.LANES(LANES)) u_fill_full (
        .acc    (acc_ins),
        .nbytes (full_cnt),
        .sext   (r_q.sext),
        .word   (full_word)
    );

    rxseg_word_fill #(.LANES(LANES)) u_fill_part (
        .acc    (r_q.acc),
        .nbytes (part_cnt),
        .sext   (r_q.sext),
        .word   (flush_word)
    );

    rxseg_seg_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seg (
        .base      (r_q.base),
        .len       (r_q.len),
        .count     (r_q.words),
        .addr      (cur_addr),
        .count_inc (words_inc),
        .last      (seg_last)
    );

    assign in_ready = (r_q.st == ST_RUN);
    assign take     = in_valid && in_ready;
    assign is_data  = (in_kind == KIND_DATA);

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.irq = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    r_d.st    = ST_RUN;
                    r_d.base  = cfg_base;
                    r_d.len   = cfg_len;
                    r_d.wide  = cfg_wide;
                    r_d.sext  = cfg_sext;
                    r_d.multi = cfg_multi;
                    r_d.words = '0;
                    r_d.lane  = '0;
                    r_d.acc   = '0;
                    r_d.eep   = 1'b0;
                    r_d.ovf   = 1'b0;
                end
            end
            ST_RUN: begin
                if (take) begin
                    if (is_data) begin
                        if (r_q.lane == last_lane) begin
                            r_d.we    = 1'b1;
                            r_d.addr  = cur_addr;
                            r_d.wdata = full_word;
                            r_d.words = words_inc;
                            r_d.lane  = '0;
                            r_d.acc   = '0;
                            if (seg_last) begin
                                r_d.st  = ST_DONE;
                                r_d.irq = 1'b1;
                                r_d.ovf = !r_q.multi;
                            end
                        end else begin
                            r_d.acc  = acc_ins;
                            r_d.lane = r_q.lane + 1'b1;
                        end
                    end else begin
                        r_d.lane = '0;
                        r_d.acc  = '0;
                        if (r_q.lane != '0) begin
                            r_d.we    = 1'b1;
                            r_d.addr  = cur_addr;
                            r_d.wdata = flush_word;
                            r_d.words = words_inc;
                        end
                        if (!r_q.multi) begin
                            r_d.st  = ST_DONE;
                            r_d.irq = 1'b1;
                            r_d.eep = in_kind[1];
                        end else if ((r_q.lane != '0) && seg_last) begin
                            r_d.st  = ST_DONE;
                            r_d.irq = 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign done      = (r_q.st == ST_DONE);
    assign done_irq  = r_q.irq;
    assign st_eep    = r_q.eep;
    assign st_ovf    = r_q.ovf;
    assign st_words  = r_q.words;

endmodule

// File: rtl/rxseg_addrgen_chk.sv
module rxseg_addrgen_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             in_ready,
    input logic             mem_we,
    input logic [31:0]      mem_wdata,
    input logic             done,
    input logic             done_irq,
    input logic             st_eep,
    input logic             st_ovf,
    input logic [LEN_W-1:0] st_words,
    input logic             wide_q,
    input logic             sext_q,
    input logic             multi_q
);

    // R6
    irq_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> done);

    // R6
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> done_irq);

    // R7
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !done);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    // R8
    ovf_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovf |-> (done && !st_eep && !multi_q));

    // R9
    multi_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_q |-> (!st_eep && !st_ovf));

    // R10
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_words == $past(st_words) + 1'b1));

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !$past(arm)) |-> $stable(st_words));

    // R4
    hi16_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wide_q && !sext_q) |-> (mem_wdata[31:16] == 16'h0000));

    // R4
    hi16_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wide_q && sext_q) |-> (mem_wdata[31:16] == {16{mem_wdata[15]}}));

endmodule

bind rxseg_addrgen rxseg_addrgen_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .done      (done),
    .done_irq  (done_irq),
    .st_eep    (st_eep),
    .st_ovf    (st_ovf),
    .st_words  (st_words),
    .wide_q    (wide_q),
    .sext_q    (sext_q),
    .multi_q   (multi_q)
);

// File: tb/rxseg_addrgen_bench.sv
module rxseg_addrgen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_len = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_sext = 1'b0;
    logic        cfg_multi = 1'b0;
    logic        arm = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [1:0]  in_kind = '0;
    logic        in_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        done;
    logic        done_irq;
    logic        st_eep;
    logic        st_ovf;
    logic [15:0] st_words;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxseg_addrgen u_rxseg_addrgen (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_wide(cfg_wide), .cfg_sext(cfg_sext), .cfg_multi(cfg_multi),
        .arm(arm), .in_valid(in_valid), .in_byte(in_byte), .in_kind(in_kind),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .done_irq(done_irq),
        .st_eep(st_eep), .st_ovf(st_ovf), .st_words(st_words)
    );

    // Memory model and event counters, sampled mid-cycle
    logic [31:0] mem [0:1023];
    int wr_cnt  = 0;
    int irq_cnt = 0;
    int checks  = 0;
    int fails   = 0;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    end

    always @(negedge clk) begin
        if (mem_we) begin
            mem[mem_addr[9:0]] = mem_wdata;
            wr_cnt++;
        end
        if (done_irq) irq_cnt++;
    end

    // One vector: format, packet bytes (first byte in bits 7:0), terminator, expected result
    typedef struct packed {
        logic        wide;
        logic        sext;
        logic [2:0]  nb;
        logic [31:0] bytes;
        logic [1:0]  kind;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [1:0]  n;
        logic        eep;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b1, 1'b0, 3'd4, 32'h44332211, 2'b01, 32'h44332211, 32'h00000000, 2'd1, 1'b0},
        '{1'b1, 1'b0, 3'd3, 32'h00C38281, 2'b10, 32'h00C38281, 32'h00000000, 2'd1, 1'b1},
        '{1'b1, 1'b1, 3'd3, 32'h00C38281, 2'b01, 32'hFFC38281, 32'h00000000, 2'd1, 1'b0},
        '{1'b1, 1'b1, 3'd2, 32'h00007F10, 2'b01, 32'h00007F10, 32'h00000000, 2'd1, 1'b0},
        '{1'b0, 1'b0, 3'd4, 32'hA1B2C3D4, 2'b01, 32'h0000C3D4, 32'h0000A1B2, 2'd2, 1'b0},
        '{1'b0, 1'b1, 3'd4, 32'hA1B2C3D4, 2'b01, 32'hFFFFC3D4, 32'hFFFFA1B2, 2'd2, 1'b0},
        '{1'b0, 1'b1, 3'd3, 32'h00853412, 2'b11, 32'h00003412, 32'hFFFFFF85, 2'd2, 1'b1},
        '{1'b0, 1'b0, 3'd1, 32'h00000090, 2'b01, 32'h00000090, 32'h00000000, 2'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_arm(input logic [15:0] b, input logic [15:0] l,
                          input logic w, input logic s, input logic m);
        @(negedge clk);
        cfg_base = b; cfg_len = l; cfg_wide = w; cfg_sext = s; cfg_multi = m;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Called at a negedge; returns at a negedge
    task automatic send(input logic [7:0] d, input logic [1:0] k, input int limit, output bit took);
        in_valid = 1'b1; in_byte = d; in_kind = k; took = 1'b0;
        for (int t = 0; t < limit; t++) begin
            if (in_ready) begin
                took = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        bit ok;
        int irq0;
        int wr0;
        logic [15:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(in_ready == 1'b0, "R1 in_ready", 32'(in_ready), 32'h0);
        chk(done == 1'b0 && done_irq == 1'b0, "R1 done", 32'(done), 32'h0);
        chk(st_words == 16'h0 && !st_eep && !st_ovf, "R1 status", 32'(st_words), 32'h0);
        chk(wr_cnt == 0, "R1 no writes", 32'(wr_cnt), 32'h0);

        // Table walk: single-packet mode, one packet per vector (R3 R4 R5 R6 R10)
        for (int i = 0; i < 8; i++) begin
            b = 16'h0100 + 16'(i * 8);
            irq0 = irq_cnt;
            do_arm(b, 16'd8, TBL[i].wide, TBL[i].sext, 1'b0);
            for (int j = 0; j < int'(TBL[i].nb); j++) begin
                send(TBL[i].bytes[8*j +: 8], 2'b00, 10, ok);
            end
            send(8'h00, TBL[i].kind, 10, ok);
            repeat (2) @(negedge clk);
            chk(done == 1'b1, "R6 done after terminator", 32'(done), 32'h1);
            chk(st_eep == TBL[i].eep, "R6 st_eep", 32'(st_eep), 32'(TBL[i].eep));
            chk(irq_cnt == irq0 + 1, "R6 one irq pulse", 32'(irq_cnt - irq0), 32'h1);
            chk(st_words == 16'(TBL[i].n), "R10 st_words", 32'(st_words), 32'(TBL[i].n));
            chk(mem[b[9:0]] == TBL[i].w0, "R3/R4/R5 word0", mem[b[9:0]], TBL[i].w0);
            if (TBL[i].n == 2'd2)
                chk(mem[b[9:0] + 10'd1] == TBL[i].w1, "R3/R4/R5 word1", mem[b[9:0] + 10'd1], TBL[i].w1);
        end

        // R2: arm while running is ignored
        do_arm(16'h0200, 16'd8, 1'b1, 1'b0, 1'b0);
        send(8'h11, 2'b00, 10, ok);
        send(8'h22, 2'b00, 10, ok);
        do_arm(16'h0280, 16'd8, 1'b0, 1'b1, 1'b1);
        send(8'h33, 2'b00, 10, ok);
        send(8'h44, 2'b00, 10, ok);
        send(8'h00, 2'b01, 10, ok);
        repeat (2) @(negedge clk);
        chk(mem[10'h200] == 32'h44332211, "R2 arm ignored while running", mem[10'h200], 32'h44332211);
        chk(mem[10'h280] == 32'h0, "R2 no write at second base", mem[10'h280], 32'h0);
        chk(done == 1'b1 && st_words == 16'd1, "R2 single stop kept", 32'(st_words), 32'h1);

        // R7: input refused while finished
        wr0 = wr_cnt;
        send(8'h55, 2'b00, 5, ok);
        chk(ok == 1'b0, "R7 byte refused", 32'(ok), 32'h0);
        chk(wr_cnt == wr0 && st_words == 16'd1, "R7 no write", 32'(wr_cnt - wr0), 32'h0);
        chk(done == 1'b1, "R7 done held", 32'(done), 32'h1);

        // R8: segment full before terminator
        irq0 = irq_cnt;
        do_arm(16'h0240, 16'd2, 1'b1, 1'b0, 1'b0);
        for (int j = 0; j < 8; j++) send(8'h30 + 8'(j), 2'b00, 10, ok);
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && st_ovf == 1'b1, "R8 overflow flagged", 32'(st_ovf), 32'h1);
        chk(st_eep == 1'b0 && st_words == 16'd2, "R8 words", 32'(st_words), 32'h2);
        chk(mem[10'h241] == 32'h37363534, "R8 last word", mem[10'h241], 32'h37363534);
        chk(irq_cnt == irq0 + 1, "R8 irq", 32'(irq_cnt - irq0), 32'h1);
        send(8'h38, 2'b00, 5, ok);
        chk(ok == 1'b0, "R8 ninth byte refused", 32'(ok), 32'h0);

        // R2: re-arm clears status
        do_arm(16'h0250, 16'd4, 1'b1, 1'b0, 1'b0);
        chk(done == 1'b0 && st_ovf == 1'b0 && st_words == 16'd0 && in_ready, "R2 re-arm clears", 32'(st_ovf), 32'h0);
        send(8'hAB, 2'b00, 10, ok);
        send(8'h00, 2'b01, 10, ok);
        repeat (2) @(negedge clk);
        chk(mem[10'h250] == 32'h000000AB, "R5 partial zero fill", mem[10'h250], 32'h000000AB);

        // R9: multi-packet mode
        irq0 = irq_cnt;
        do_arm(16'h0300, 16'd3, 1'b1, 1'b0, 1'b1);
        send(8'h01, 2'b00, 10, ok); send(8'h02, 2'b00, 10, ok); send(8'h03, 2'b00, 10, ok);
        send(8'h00, 2'b01, 10, ok);
        for (int j = 0; j < 4; j++) send(8'h11 + 8'(j), 2'b00, 10, ok);
        send(8'h00, 2'b10, 10, ok);
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && in_ready == 1'b1, "R9 running after terminators", 32'(done), 32'h0);
        chk(st_words == 16'd2, "R9 words so far", 32'(st_words), 32'h2);
        chk(mem[10'h300] == 32'h00030201, "R9 flushed packet", mem[10'h300], 32'h00030201);
        chk(mem[10'h301] == 32'h14131211, "R9 contiguous packet", mem[10'h301], 32'h14131211);
        chk(irq_cnt == irq0, "R9 no per-packet irq", 32'(irq_cnt - irq0), 32'h0);
        for (int j = 0; j < 4; j++) send(8'h21 + 8'(j), 2'b00, 10, ok);
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && irq_cnt == irq0 + 1, "R9 segment end", 32'(irq_cnt - irq0), 32'h1);
        chk(!st_ovf && !st_eep && st_words == 16'd3, "R9 status", 32'(st_words), 32'h3);
        chk(mem[10'h302] == 32'h24232221, "R9 last word", mem[10'h302], 32'h24232221);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule